// File: doc/BRIEF.md
# Multidrop Station Address Filter

This block sits between a UART receiver and the receive-buffer logic of a station on a shared multidrop line. Each received character arrives as a single-cycle strobe carrying nine bits: eight character bits and a ninth flag that marks the character as a station address (flag high) or as payload (flag low). The block decides whether each character is stored. For every stored character it also reports whether a new buffer must be opened and which of the two programmed station addresses the current frame belongs to.

A two-bit mode input selects the behaviour. `2'b11` is automatic filtering. An address character is compared against two programmed 8-bit station addresses. A hit opens a frame, and the following payload is stored. A miss closes the frame, and the following payload is dropped. `2'b01` is non-automatic operation: every character is stored, and each address character requests a new buffer. `2'b00` and `2'b10` are plain operation: every character is stored and the flag bit is ignored. A seven-bit option limits the address comparison to bits 6:0.

The controlling state machine has three states:
- `ST_HUNT`: no frame is open.
- `ST_ACC_A`: a frame addressed to station register A is open.
- `ST_ACC_B`: a frame addressed to station register B is open.

Its transitions are:
- hit_a: an address character that equals A moves the machine to `ST_ACC_A`, from any state.
- hit_b: an address character that equals B but not A moves the machine to `ST_ACC_B`.
- miss: an address character that equals neither moves the machine to `ST_HUNT`.
- leave_auto: any cycle with a mode other than `2'b11` forces the machine to `ST_HUNT`.

Payload characters never change the state.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset all outputs are 0 and no frame is open. A payload character received in automatic mode before any address character is not stored.
- R2: In modes 2'b00 and 2'b10, every strobed character is stored with new_buf_o=0 and match_id_o=0, whatever the value of flag bit 8.
- R3: In mode 2'b01, every strobed character is stored, and new_buf_o equals its flag bit 8. match_id_o is 0.
- R4: In mode 2'b11, an address character equal to station A is stored with new_buf_o=1 and match_id_o=0. The payload characters that follow are stored with new_buf_o=0 and match_id_o=0.
- R5: In mode 2'b11, an address character equal to station B but not to A is stored with new_buf_o=1 and match_id_o=1. The payload characters that follow are stored with match_id_o=1.
- R6: An address character equal to both stations reports station A (match_id_o=0).
- R7: In mode 2'b11, an address character equal to neither station is not stored. The payload characters after it are not stored until the next matching address character arrives.
- R8: With seven_bit_i=1, only bits 6:0 of the character and of the station addresses are compared, and bit 7 is ignored. With seven_bit_i=0, all eight bits are compared.
- R9: The outputs for a strobed character appear exactly one clock after the strobe. In a cycle without a strobe one clock earlier, store_o, new_buf_o, match_id_o and data_o are all 0.
- R10: Any cycle in a mode other than 2'b11 closes an open frame. After a return to 2'b11, payload is dropped until a matching address character arrives.
- R11: When store_o=1, data_o equals bits 7:0 of the stored character. Otherwise data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 11 automatic, 01 non-automatic, 00/10 plain |
| seven_bit_i | input | 1 | Compare only bits 6:0 of addresses |
| station_a_i | input | 8 | First station address (takes priority) |
| station_b_i | input | 8 | Second station address |
| rx_valid_i | input | 1 | Single-cycle character strobe |
| rx_char_i | input | 9 | Bit 8 address flag, bits 7:0 character |
| store_o | output | 1 | Character is to be stored |
| new_buf_o | output | 1 | Open a new buffer for this character |
| match_id_o | output | 1 | 0 station A frame, 1 station B frame |
| data_o | output | 8 | Stored character bits |

## Verification
A wrong frame state shows up at the first payload character after it goes wrong. store_o is asserted when it should be 0 or dropped when it should be 1, or match_id_o names the wrong station, one clock after that payload strobe. An error in comparison or priority shows up in the cycle after the address character itself, through store_o, new_buf_o and match_id_o. A stale frame left open across a mode change is exposed by the first payload character after automatic mode is re-entered.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
    localparam int NUM_STATIONS = 2;

    typedef enum logic [1:0] {
        MD_PLAIN0  = 2'b00,
        MD_NONAUTO = 2'b01,
        MD_PLAIN1  = 2'b10,
        MD_AUTO    = 2'b11
    } mdf_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ACC_A = 2'd1,
        ST_ACC_B = 2'd2
    } mdf_state_e;
endpackage

// File: rtl/mdf_addr_cmp.sv
module mdf_addr_cmp #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] char_i,
    input  logic [CHAR_W-1:0] station_i,
    input  logic              seven_bit_i,
    output logic              hit_o
);
    localparam int LOW_W = CHAR_W - 1;

    logic low_eq;
    logic top_eq;

    always_comb begin
        low_eq = (char_i[LOW_W-1:0] == station_i[LOW_W-1:0]);
        top_eq = (char_i[CHAR_W-1] == station_i[CHAR_W-1]);
        hit_o  = low_eq && (seven_bit_i || top_eq);
    end
endmodule

// File: rtl/mdf_frame_fsm.sv
module mdf_frame_fsm
    import mdf_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mdf_mode_e         mode_i,
    input  logic              valid_i,
    input  logic              is_addr_i,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              hit_a_i,
    input  logic              hit_b_i,
    output logic              store_o,
    output logic              new_buf_o,
    output logic              match_id_o,
    output logic [CHAR_W-1:0] data_o
);
    mdf_state_e state_q, state_d;
    logic auto_mode;
    logic store_d, new_buf_d, match_d;
    logic [CHAR_W-1:0] data_d;

    assign auto_mode = (mode_i == MD_AUTO);

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (!auto_mode) begin
            state_d = ST_HUNT;                      // leave_auto
        end else if (valid_i && is_addr_i) begin
            if (hit_a_i)      state_d = ST_ACC_A;   // hit_a
            else if (hit_b_i) state_d = ST_ACC_B;   // hit_b
            else              state_d = ST_HUNT;    // miss
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        store_d   = 1'b0;
        new_buf_d = 1'b0;
        match_d   = 1'b0;
        if (valid_i) begin
            unique case (mode_i)
                MD_AUTO: begin
                    if (is_addr_i) begin
                        if (hit_a_i) begin
                            store_d   = 1'b1;
                            new_buf_d = 1'b1;
                        end else if (hit_b_i) begin
                            store_d   = 1'b1;
                            new_buf_d = 1'b1;
                            match_d   = 1'b1;
                        end
                    end else begin
                        unique case (state_q)
                            ST_ACC_A: store_d = 1'b1;
                            ST_ACC_B: begin
                                store_d = 1'b1;
                                match_d = 1'b1;
                            end
                            default:  store_d = 1'b0;
                        endcase
                    end
                end
                MD_NONAUTO: begin
                    store_d   = 1'b1;
                    new_buf_d = is_addr_i;
                end
                MD_PLAIN0, MD_PLAIN1: store_d = 1'b1;
                default: store_d = 1'b0;
            endcase
        end
        data_d = store_d ? char_i : '0;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_o    <= 1'b0;
            new_buf_o  <= 1'b0;
            match_id_o <= 1'b0;
            data_o     <= '0;
        end else begin
            store_o    <= store_d;
            new_buf_o  <= new_buf_d;
            match_id_o <= match_d;
            data_o     <= data_d;
        end
    end

    a_r9_store_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> $past(valid_i));

    a_r2_plain_passes_all: assert property (@(posedge clk) disable iff (!rst_n)
        $past(valid_i && !mode_i[0]) |-> (store_o && !new_buf_o && !match_id_o));

    a_r3_nonauto_newbuf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(valid_i && mode_i == MD_NONAUTO) |-> (store_o && new_buf_o == $past(is_addr_i)));

    a_r7_hunt_drops_payload: assert property (@(posedge clk) disable iff (!rst_n)
        $past(valid_i && auto_mode && !is_addr_i && state_q == ST_HUNT) |-> !store_o);

    a_r6_station_a_priority: assert property (@(posedge clk) disable iff (!rst_n)
        $past(valid_i && auto_mode && is_addr_i && hit_a_i) |-> (store_o && new_buf_o && !match_id_o));

    a_r10_leave_auto_closes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!auto_mode) |-> (state_q == ST_HUNT));
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdf_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              seven_bit_i,
    input  logic [CHAR_W-1:0] station_a_i,
    input  logic [CHAR_W-1:0] station_b_i,
    input  logic              rx_valid_i,
    input  logic [CHAR_W:0]   rx_char_i,
    output logic              store_o,
    output logic              new_buf_o,
    output logic              match_id_o,
    output logic [CHAR_W-1:0] data_o
);
    logic [NUM_STATIONS-1:0][CHAR_W-1:0] stations;
    logic [NUM_STATIONS-1:0]             hits;

    assign stations = {station_b_i, station_a_i};

    for (genvar g = 0; g < NUM_STATIONS; g++) begin : g_cmp
        mdf_addr_cmp #(.CHAR_W(CHAR_W)) cmp_i (
            .char_i      (rx_char_i[CHAR_W-1:0]),
            .station_i   (stations[g]),
            .seven_bit_i (seven_bit_i),
            .hit_o       (hits[g])
        );
    end

    mdf_frame_fsm #(.CHAR_W(CHAR_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mdf_mode_e'(mode_i)),
        .valid_i    (rx_valid_i),
        .is_addr_i  (rx_char_i[CHAR_W]),
        .char_i     (rx_char_i[CHAR_W-1:0]),
        .hit_a_i    (hits[0]),
        .hit_b_i    (hits[1]),
        .store_o    (store_o),
        .new_buf_o  (new_buf_o),
        .match_id_o (match_id_o),
        .data_o     (data_o)
    );
endmodule

// File: tb/mdrop_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mdrop_addr_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       sev = 1'b0;
    logic [7:0] sta = 8'h00;
    logic [7:0] stb = 8'h00;
    logic       vld = 1'b0;
    logic [8:0] ch  = 9'h000;
    logic       store, nbuf, mid;
    logic [7:0] dout;

    int checks = 0;
    int fails  = 0;
    int acc    = 0;   // bench frame state: 0 none, 1 station A, 2 station B

    always #4 clk = ~clk;

    mdrop_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .seven_bit_i(sev),
        .station_a_i(sta), .station_b_i(stb), .rx_valid_i(vld), .rx_char_i(ch),
        .store_o(store), .new_buf_o(nbuf), .match_id_o(mid), .data_o(dout)
    );

    function automatic bit cmp(input logic [7:0] c, input logic [7:0] s, input logic seven);
        if (seven) return c[6:0] == s[6:0];
        return c == s;
    endfunction

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: store/nbuf/mid/data actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle, predict, then check at the next falling edge
    task automatic step(input string tag, input logic v, input logic [8:0] c);
        logic es, en, em;
        logic [7:0] ed;
        vld = v;
        ch  = c;
        es = 0; en = 0; em = 0;
        if (mode != 2'b11) begin
            acc = 0;
            if (v) begin
                es = 1;
                en = (mode == 2'b01) && c[8];
            end
        end else if (v) begin
            if (c[8]) begin
                if (cmp(c[7:0], sta, sev))      begin acc = 1; es = 1; en = 1; end
                else if (cmp(c[7:0], stb, sev)) begin acc = 2; es = 1; en = 1; em = 1; end
                else acc = 0;
            end else begin
                es = (acc != 0);
                em = (acc == 2);
            end
        end
        ed = es ? c[7:0] : 8'h00;
        @(negedge clk);
        check(tag, {store, nbuf, mid, dout}, {es, en, em, ed});
        vld = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {store, nbuf, mid, dout}, 11'h0);

        // R1: payload in auto mode before any address is dropped
        mode = 2'b11; sta = 8'h41; stb = 8'h42;
        step("R1", 1, 9'h055);
        // R9: no strobe gives zero outputs
        step("R9", 0, 9'h141);
        // R4: station A frame
        step("R4", 1, 9'h141);
        step("R4", 1, 9'h0AA);
        step("R11", 1, 9'h0F0);
        // R5: station B frame
        step("R5", 1, 9'h142);
        step("R5", 1, 9'h011);
        // R7: miss closes frame
        step("R7", 1, 9'h199);
        step("R7", 1, 9'h022);
        step("R7", 1, 9'h033);
        // R6: both registers equal
        stb = 8'h41;
        step("R6", 1, 9'h141);
        step("R6", 1, 9'h044);
        // R8: seven-bit compare ignores bit 7
        sta = 8'h10; stb = 8'h20;
        sev = 1'b1;
        step("R8", 1, 9'h1A0);
        step("R8", 1, 9'h077);
        sev = 1'b0;
        step("R8", 1, 9'h1A0);
        step("R8", 1, 9'h078);
        step("R8", 1, 9'h110);
        // R10: leaving auto mode closes frame
        mode = 2'b00;
        step("R10", 0, 9'h000);
        mode = 2'b11;
        step("R10", 1, 9'h066);
        // R3: non-automatic
        mode = 2'b01;
        step("R3", 1, 9'h1C3);
        step("R3", 1, 9'h0C4);
        // R2: plain modes ignore flag
        mode = 2'b10;
        step("R2", 1, 9'h1C5);
        mode = 2'b00;
        step("R2", 1, 9'h0C6);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [8:0] c;
            int pick;
            string tag;
            if ($urandom_range(0, 15) == 0) mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 31) == 0) sev = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 63) == 0) begin
                sta = 8'($urandom_range(0, 255));
                stb = 8'($urandom_range(0, 255));
            end
            pick = $urandom_range(0, 3);
            c = 9'($urandom_range(0, 511));
            if (c[8] && pick == 0) c[7:0] = sta ^ (sev ? 8'h80 : 8'h00);
            if (c[8] && pick == 1) c[7:0] = stb;
            case (mode)
                2'b11:   tag = "R7";
                2'b01:   tag = "R3";
                default: tag = "R2";
            endcase
            step(tag, 1'($urandom_range(0, 4) != 0), c);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule